// File: doc/BRIEF.md
# Special-Purpose Register Access Unit

This block serves the move-to and move-from special-register operations of a small RISC core. The core presents a 16-bit register address. It also presents a write value with a write strobe, or a read strobe with a fallback value. The unit decodes the address and routes the access to one of its architectural registers. The address is built as the group number shifted left by 11, plus the register number inside that group.

The unit holds these registers:
- the vector base and version registers;
- the plain exception-context registers;
- a banked shadow register file;
- a 64-bit multiply-accumulate register, reached as two 32-bit halves;
- the power-management register;
- the interrupt mask and interrupt pending registers.

Each register has its own access rule. Writes to the pending register clear bits. The accumulator is written one half at a time. A power-mode write asks the core to halt. Writing a new next-PC value redirects the core. Any read that decodes to nothing hands back the fallback value the core supplied.

Read data is combinational from the address. Writes land on the clock edge at which the write strobe is high. The halt and redirect side effects appear as single-cycle pulses on the cycle after that edge.

Top module: `sprUnit`

## Requirements
- R1: After reset every writable register reads 0, and `haltPulse` and `redirectPulse` are low.
- R2: The address is (group << 11) + number. The following are plain 32-bit read/write registers: group 0 numbers 11 (vector base), 17 (status), 18 (previous PC), 32 (exception PC), 48 (exception address) and 64 (exception status), and group 9 number 0 (interrupt mask).
- R3: The version register, group 0 number 0, is writable. It reads back ANDed with `VER_MASK` (default 32'h00FF_FFFF).
- R4: Group 0 numbers 1, 2, 128 and 129 read the parameters `UNIT_PRESENT`, `CPU_CFG`, `CORE_ID` and `CORE_COUNT`. Writes to these addresses change nothing.
- R5: Group 0 addresses 1024 to 1024+SETS*REGS-1 reach the shadow file. The offset from 1024 divided by REGS selects the set, and the offset modulo REGS selects the entry in that set. Each entry holds its own value.
- R6: Group 5 number 1 is the low 32 bits of the accumulator and number 2 is the high 32 bits. A write replaces only the addressed half.
- R7: At group 9 number 2, the interrupt pending register clears each bit written as 1 and keeps each bit written as 0. Every bit of `irqSet` that is high at a clock edge is set. When a set and a clear hit the same bit in the same edge, the set wins.
- R8: A write to the power-management register, group 8 number 0, that has bit 4 (doze) or bit 5 (sleep) set raises `haltPulse` for exactly the next cycle. In that cycle `resumePc` equals the `curPc` of the write cycle plus 4. Other values only store. The register reads back what was written.
- R9: A write to next-PC, group 0 number 16, with a value different from `curPc` raises `redirectPulse` for exactly the next cycle, with `redirectPc` equal to the written value. The core also clears its delay-slot state on this pulse. A write equal to `curPc` raises no pulse. Reading this address returns `curPc`.
- R10: A read of an address that decodes to no register, or any cycle with `rdEn` low, returns `rdDefault` unchanged.
- R11: Read data follows the address in the same cycle. A written value is readable from the cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sprAddr | input | 16 | Register address, (group << 11) + number |
| wrData | input | 32 | Write value |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| rdDefault | input | 32 | Value returned for reads that decode to nothing |
| curPc | input | 32 | Address of the current instruction |
| irqSet | input | 32 | Interrupt lines that set pending bits |
| rdData | output | 32 | Read result |
| redirectPulse | output | 1 | One-cycle request to jump to `redirectPc` and clear delay-slot state |
| redirectPc | output | 32 | Redirect target |
| haltPulse | output | 1 | One-cycle halt request |
| resumePc | output | 32 | Address to resume from after a halt |

## Verification
The interrupt pending register can receive a software clear and a hardware set in the same clock edge. The bench provokes this by driving `irqSet` during a clearing write. In one case both target the same bit. In another they target different bits. The bench then reads the register back and compares the result with the rule that a set overrides a clear while untouched bits keep their value. A second pairing is a power-mode write that stores a value while also raising a halt. Both the pulse and the stored value are checked.

// File: rtl/sprPkg.sv
package sprPkg;

  function automatic logic [15:0] sprAddrOf(input int grp, input int num);
    return 16'((grp << 11) + num);
  endfunction

  localparam logic [15:0] A_VER    = 16'h0000;
  localparam logic [15:0] A_UPR    = 16'h0001;
  localparam logic [15:0] A_CFG    = 16'h0002;
  localparam logic [15:0] A_VBASE  = 16'h000B;
  localparam logic [15:0] A_NPC    = 16'h0010;
  localparam logic [15:0] A_SR     = 16'h0011;
  localparam logic [15:0] A_PPC    = 16'h0012;
  localparam logic [15:0] A_EPC    = 16'h0020;
  localparam logic [15:0] A_EEAR   = 16'h0030;
  localparam logic [15:0] A_ESR    = 16'h0040;
  localparam logic [15:0] A_COREID = 16'h0080;
  localparam logic [15:0] A_NCORES = 16'h0081;
  localparam logic [15:0] A_MACLO  = 16'h2801;
  localparam logic [15:0] A_MACHI  = 16'h2802;
  localparam logic [15:0] A_PM     = 16'h4000;
  localparam logic [15:0] A_IMASK  = 16'h4800;
  localparam logic [15:0] A_ISTAT  = 16'h4802;
  localparam int          SHADOW_BASE = 1024;

  localparam int PM_DOZE_BIT  = 4;
  localparam int PM_SLEEP_BIT = 5;

  typedef enum logic [4:0] {
    RS_NONE, RS_VER, RS_UPR, RS_CFG, RS_VBASE, RS_NPC, RS_SR, RS_PPC,
    RS_EPC, RS_EEAR, RS_ESR, RS_COREID, RS_NCORES, RS_SHADOW,
    RS_MACLO, RS_MACHI, RS_PM, RS_IMASK, RS_ISTAT
  } readSel_e;

  typedef struct packed {
    logic     wrVer;
    logic     wrVbase;
    logic     wrNpc;
    logic     wrSr;
    logic     wrPpc;
    logic     wrEpc;
    logic     wrEear;
    logic     wrEsr;
    logic     wrShadow;
    logic     wrMacLo;
    logic     wrMacHi;
    logic     wrPm;
    logic     wrImask;
    logic     wrIstat;
    readSel_e readSel;
  } sprStrobes_t;

endpackage

// File: rtl/sprCtrl.sv
module sprCtrl
  import sprPkg::*;
#(
  parameter int SHADOW_SETS = 16,
  parameter int SHADOW_REGS = 32,
  localparam int SHADOW_TOTAL = SHADOW_SETS * SHADOW_REGS,
  localparam int IDXW = $clog2(SHADOW_TOTAL)
) (
  input  logic [15:0]      sprAddr,
  input  logic             wrEn,
  input  logic             rdEn,
  output sprStrobes_t      strobes,
  output logic [IDXW-1:0]  shadowIdx
);

  readSel_e hit;
  logic     inShadow;
  logic [15:0] offset;

  assign offset    = sprAddr - 16'(SHADOW_BASE);
  assign inShadow  = (int'(sprAddr) >= SHADOW_BASE) &&
                     (int'(sprAddr) < SHADOW_BASE + SHADOW_TOTAL);
  assign shadowIdx = offset[IDXW-1:0];

  always_comb begin
    hit = RS_NONE;
    if (inShadow) hit = RS_SHADOW;
    else begin
      case (sprAddr)
        A_VER:    hit = RS_VER;
        A_UPR:    hit = RS_UPR;
        A_CFG:    hit = RS_CFG;
        A_VBASE:  hit = RS_VBASE;
        A_NPC:    hit = RS_NPC;
        A_SR:     hit = RS_SR;
        A_PPC:    hit = RS_PPC;
        A_EPC:    hit = RS_EPC;
        A_EEAR:   hit = RS_EEAR;
        A_ESR:    hit = RS_ESR;
        A_COREID: hit = RS_COREID;
        A_NCORES: hit = RS_NCORES;
        A_MACLO:  hit = RS_MACLO;
        A_MACHI:  hit = RS_MACHI;
        A_PM:     hit = RS_PM;
        A_IMASK:  hit = RS_IMASK;
        A_ISTAT:  hit = RS_ISTAT;
        default:  hit = RS_NONE;
      endcase
    end
  end

  always_comb begin
    strobes.wrVer    = wrEn && (hit == RS_VER);
    strobes.wrVbase  = wrEn && (hit == RS_VBASE);
    strobes.wrNpc    = wrEn && (hit == RS_NPC);
    strobes.wrSr     = wrEn && (hit == RS_SR);
    strobes.wrPpc    = wrEn && (hit == RS_PPC);
    strobes.wrEpc    = wrEn && (hit == RS_EPC);
    strobes.wrEear   = wrEn && (hit == RS_EEAR);
    strobes.wrEsr    = wrEn && (hit == RS_ESR);
    strobes.wrShadow = wrEn && (hit == RS_SHADOW);
    strobes.wrMacLo  = wrEn && (hit == RS_MACLO);
    strobes.wrMacHi  = wrEn && (hit == RS_MACHI);
    strobes.wrPm     = wrEn && (hit == RS_PM);
    strobes.wrImask  = wrEn && (hit == RS_IMASK);
    strobes.wrIstat  = wrEn && (hit == RS_ISTAT);
    strobes.readSel  = rdEn ? hit : RS_NONE;
  end

endmodule

// File: rtl/sprData.sv
module sprData
  import sprPkg::*;
#(
  parameter int SHADOW_SETS = 16,
  parameter int SHADOW_REGS = 32,
  parameter logic [31:0] VER_MASK     = 32'h00FF_FFFF,
  parameter logic [31:0] UNIT_PRESENT = 32'h0000_0605,
  parameter logic [31:0] CPU_CFG      = 32'h0000_0020,
  parameter logic [31:0] CORE_ID      = 32'h0000_0000,
  parameter logic [31:0] CORE_COUNT   = 32'h0000_0001,
  localparam int SHADOW_TOTAL = SHADOW_SETS * SHADOW_REGS,
  localparam int IDXW = $clog2(SHADOW_TOTAL)
) (
  input  logic             clk,
  input  logic             rstN,
  input  sprStrobes_t      strobes,
  input  logic [IDXW-1:0]  shadowIdx,
  input  logic [31:0]      wrData,
  input  logic [31:0]      rdDefault,
  input  logic [31:0]      curPc,
  input  logic [31:0]      irqSet,
  output logic [31:0]      rdData,
  output logic             redirectPulse,
  output logic [31:0]      redirectPc,
  output logic             haltPulse,
  output logic [31:0]      resumePc
);

  logic [31:0] verReg, vbaseReg, srReg, ppcReg, epcReg, eearReg, esrReg;
  logic [31:0] pmReg, imaskReg, istatReg;
  logic [63:0] macReg;
  logic [31:0] shadowMem [SHADOW_TOTAL];
  logic [31:0] clearMask;
  logic        wantHalt, wantRedirect;

  assign clearMask    = strobes.wrIstat ? wrData : 32'h0;
  assign wantHalt     = strobes.wrPm && (wrData[PM_DOZE_BIT] || wrData[PM_SLEEP_BIT]);
  assign wantRedirect = strobes.wrNpc && (wrData != curPc);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      verReg <= '0; vbaseReg <= '0; srReg <= '0; ppcReg <= '0;
      epcReg <= '0; eearReg <= '0; esrReg <= '0; pmReg <= '0;
      imaskReg <= '0; istatReg <= '0; macReg <= '0;
    end else begin
      if (strobes.wrVer)   verReg   <= wrData;
      if (strobes.wrVbase) vbaseReg <= wrData;
      if (strobes.wrSr)    srReg    <= wrData;
      if (strobes.wrPpc)   ppcReg   <= wrData;
      if (strobes.wrEpc)   epcReg   <= wrData;
      if (strobes.wrEear)  eearReg  <= wrData;
      if (strobes.wrEsr)   esrReg   <= wrData;
      if (strobes.wrPm)    pmReg    <= wrData;
      if (strobes.wrImask) imaskReg <= wrData;
      if (strobes.wrMacLo) macReg[31:0]  <= wrData;
      if (strobes.wrMacHi) macReg[63:32] <= wrData;
      istatReg <= (istatReg & ~clearMask) | irqSet;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < SHADOW_TOTAL; i++) shadowMem[i] <= '0;
    end else if (strobes.wrShadow) begin
      shadowMem[shadowIdx] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      redirectPulse <= 1'b0;
      redirectPc    <= '0;
      haltPulse     <= 1'b0;
      resumePc      <= '0;
    end else begin
      redirectPulse <= wantRedirect;
      haltPulse     <= wantHalt;
      if (wantRedirect) redirectPc <= wrData;
      if (wantHalt)     resumePc   <= curPc + 32'd4;
    end
  end

  always_comb begin
    case (strobes.readSel)
      RS_VER:    rdData = verReg & VER_MASK;
      RS_UPR:    rdData = UNIT_PRESENT;
      RS_CFG:    rdData = CPU_CFG;
      RS_VBASE:  rdData = vbaseReg;
      RS_NPC:    rdData = curPc;
      RS_SR:     rdData = srReg;
      RS_PPC:    rdData = ppcReg;
      RS_EPC:    rdData = epcReg;
      RS_EEAR:   rdData = eearReg;
      RS_ESR:    rdData = esrReg;
      RS_COREID: rdData = CORE_ID;
      RS_NCORES: rdData = CORE_COUNT;
      RS_SHADOW: rdData = shadowMem[shadowIdx];
      RS_MACLO:  rdData = macReg[31:0];
      RS_MACHI:  rdData = macReg[63:32];
      RS_PM:     rdData = pmReg;
      RS_IMASK:  rdData = imaskReg;
      RS_ISTAT:  rdData = istatReg;
      default:   rdData = rdDefault;
    endcase
  end

endmodule

// File: rtl/sprUnit.sv
module sprUnit
  import sprPkg::*;
#(
  parameter int SHADOW_SETS = 16,
  parameter int SHADOW_REGS = 32,
  parameter logic [31:0] VER_MASK     = 32'h00FF_FFFF,
  parameter logic [31:0] UNIT_PRESENT = 32'h0000_0605,
  parameter logic [31:0] CPU_CFG      = 32'h0000_0020,
  parameter logic [31:0] CORE_ID      = 32'h0000_0000,
  parameter logic [31:0] CORE_COUNT   = 32'h0000_0001
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:0] sprAddr,
  input  logic [31:0] wrData,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic [31:0] rdDefault,
  input  logic [31:0] curPc,
  input  logic [31:0] irqSet,
  output logic [31:0] rdData,
  output logic        redirectPulse,
  output logic [31:0] redirectPc,
  output logic        haltPulse,
  output logic [31:0] resumePc
);

  localparam int IDXW = $clog2(SHADOW_SETS * SHADOW_REGS);

  sprStrobes_t     strobes;
  logic [IDXW-1:0] shadowIdx;

  sprCtrl #(.SHADOW_SETS(SHADOW_SETS), .SHADOW_REGS(SHADOW_REGS)) uCtrl (
    .sprAddr(sprAddr), .wrEn(wrEn), .rdEn(rdEn),
    .strobes(strobes), .shadowIdx(shadowIdx)
  );

  sprData #(
    .SHADOW_SETS(SHADOW_SETS), .SHADOW_REGS(SHADOW_REGS),
    .VER_MASK(VER_MASK), .UNIT_PRESENT(UNIT_PRESENT), .CPU_CFG(CPU_CFG),
    .CORE_ID(CORE_ID), .CORE_COUNT(CORE_COUNT)
  ) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .shadowIdx(shadowIdx),
    .wrData(wrData), .rdDefault(rdDefault), .curPc(curPc), .irqSet(irqSet),
    .rdData(rdData), .redirectPulse(redirectPulse), .redirectPc(redirectPc),
    .haltPulse(haltPulse), .resumePc(resumePc)
  );

endmodule

// File: rtl/sprUnitChk.sv
module sprUnitChk
  import sprPkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic [15:0] sprAddr,
  input logic [31:0] wrData,
  input logic        wrEn,
  input logic        rdEn,
  input logic [31:0] rdDefault,
  input logic [31:0] curPc,
  input logic [31:0] irqSet,
  input logic [31:0] rdData,
  input logic        redirectPulse,
  input logic [31:0] redirectPc,
  input logic        haltPulse,
  input logic [31:0] resumePc
);

  // R9: a differing next-PC write yields the pulse and its target
  p_redirect_fire_r9: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && sprAddr == A_NPC && wrData != curPc) |=>
      (redirectPulse && redirectPc == $past(wrData)));

  // R9: no pulse without a differing next-PC write
  p_redirect_only_r9: assert property (@(posedge clk) disable iff (!rstN)
    redirectPulse |-> $past(wrEn && sprAddr == A_NPC && wrData != curPc));

  // R8: doze or sleep write yields halt with resume address
  p_halt_fire_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && sprAddr == A_PM && (wrData[PM_DOZE_BIT] || wrData[PM_SLEEP_BIT])) |=>
      (haltPulse && resumePc == $past(curPc) + 32'd4));

  // R8: halt only after such a write
  p_halt_only_r8: assert property (@(posedge clk) disable iff (!rstN)
    haltPulse |-> $past(wrEn && sprAddr == A_PM &&
                        (wrData[PM_DOZE_BIT] || wrData[PM_SLEEP_BIT])));

  // R10: undecoded group 3 address falls through to the default
  p_unmapped_default_r10: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && sprAddr[15:11] == 5'd3) |-> rdData == rdDefault);

  // R6: high half written last cycle reads back unchanged
  p_mac_half_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && sprAddr == A_MACHI && $past(wrEn && sprAddr == A_MACHI)) |->
      rdData == $past(wrData));

endmodule

bind sprUnit sprUnitChk uChk (
  .clk(clk), .rstN(rstN), .sprAddr(sprAddr), .wrData(wrData), .wrEn(wrEn),
  .rdEn(rdEn), .rdDefault(rdDefault), .curPc(curPc), .irqSet(irqSet),
  .rdData(rdData), .redirectPulse(redirectPulse), .redirectPc(redirectPc),
  .haltPulse(haltPulse), .resumePc(resumePc)
);

// File: tb/tb_sprUnit.sv
`timescale 1ns/1ps
module tb_sprUnit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] sprAddr = '0;
  logic [31:0] wrData = '0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [31:0] rdDefault = '0;
  logic [31:0] curPc = 32'h0000_1000;
  logic [31:0] irqSet = '0;
  logic [31:0] rdData, redirectPc, resumePc;
  logic        redirectPulse, haltPulse;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    int          kind;   // 0 read, 1 redirect, 2 halt
    logic [31:0] expVal;
    logic        expBit;
    string       tag;
  } item_t;
  item_t sbQ[$];

  sprUnit dut (
    .clk(clk), .rstN(rstN), .sprAddr(sprAddr), .wrData(wrData), .wrEn(wrEn),
    .rdEn(rdEn), .rdDefault(rdDefault), .curPc(curPc), .irqSet(irqSet),
    .rdData(rdData), .redirectPulse(redirectPulse), .redirectPc(redirectPc),
    .haltPulse(haltPulse), .resumePc(resumePc)
  );

  always #5 clk = ~clk;

  // monitor: compares queued expectations 2 ns after each falling edge
  always @(negedge clk) begin
    #2;
    while (sbQ.size() > 0) begin
      item_t it;
      it = sbQ.pop_front();
      checks++;
      if (it.kind == 0) begin
        if (rdData !== it.expVal) begin
          errors++;
          $display("FAIL %s rdData actual=%h expected=%h", it.tag, rdData, it.expVal);
        end
      end else begin
        logic p; logic [31:0] v;
        p = (it.kind == 1) ? redirectPulse : haltPulse;
        v = (it.kind == 1) ? redirectPc : resumePc;
        if (p !== it.expBit || (it.expBit && v !== it.expVal)) begin
          errors++;
          $display("FAIL %s pulse/addr actual=%b/%h expected=%b/%h",
                   it.tag, p, v, it.expBit, it.expVal);
        end
      end
    end
  end

  task automatic wrIrq(input logic [15:0] a, input logic [31:0] d, input logic [31:0] irq);
    @(negedge clk);
    sprAddr = a; wrData = d; wrEn = 1'b1; rdEn = 1'b0; irqSet = irq;
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    wrIrq(a, d, 32'h0);
  endtask

  task automatic rdChk(input logic [15:0] a, input logic [31:0] dflt,
                       input logic en, input logic [31:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    sprAddr = a; wrEn = 1'b0; rdEn = en; rdDefault = dflt; irqSet = '0;
    it.kind = 0; it.expVal = exp; it.expBit = 1'b0; it.tag = tag;
    sbQ.push_back(it);
  endtask

  task automatic pulseChk(input int kind, input logic b, input logic [31:0] v,
                          input string tag);
    item_t it;
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0; irqSet = '0; sprAddr = 16'h1800;
    it.kind = kind; it.expVal = v; it.expBit = b; it.tag = tag;
    sbQ.push_back(it);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    rdChk(16'h000B, 32'h5555_5555, 1, 32'h0, "R1 vbase reset");
    rdChk(16'h4800, 32'h5555_5555, 1, 32'h0, "R1 mask reset");
    rdChk(16'h2802, 32'h5555_5555, 1, 32'h0, "R1 mac hi reset");
    pulseChk(1, 1'b0, 32'h0, "R1 redirect low");
    pulseChk(2, 1'b0, 32'h0, "R1 halt low");
    // R2 / R11 plain registers
    wr(16'h000B, 32'h1234_5678);
    rdChk(16'h000B, 32'h0, 1, 32'h1234_5678, "R2 R11 vbase");
    wr(16'h0011, 32'hA5A5_0F0F);
    wr(16'h0020, 32'h0000_2468);
    wr(16'h0040, 32'hCAFE_0001);
    rdChk(16'h0011, 32'h0, 1, 32'hA5A5_0F0F, "R2 status");
    rdChk(16'h0020, 32'h0, 1, 32'h0000_2468, "R2 exc pc");
    rdChk(16'h0040, 32'h0, 1, 32'hCAFE_0001, "R2 exc status");
    wr(16'h4800, 32'h0000_FF00);
    rdChk(16'h4800, 32'h0, 1, 32'h0000_FF00, "R2 mask");
    // R3 version masking
    wr(16'h0000, 32'hFFFF_FFFF);
    rdChk(16'h0000, 32'h0, 1, 32'h00FF_FFFF, "R3 version mask");
    // R4 read-only parameters
    wr(16'h0001, 32'hFFFF_FFFF);
    rdChk(16'h0001, 32'h0, 1, 32'h0000_0605, "R4 unit present");
    rdChk(16'h0081, 32'h0, 1, 32'h0000_0001, "R4 core count");
    rdChk(16'h0002, 32'h0, 1, 32'h0000_0020, "R4 cpu cfg");
    // R5 shadow file
    wr(16'd1125, 32'hBEEF_0305);
    wr(16'd1024, 32'h0000_0001);
    wr(16'd1535, 32'hFFFF_0F1F);
    rdChk(16'd1125, 32'h0, 1, 32'hBEEF_0305, "R5 set3 reg5");
    rdChk(16'd1024, 32'h0, 1, 32'h0000_0001, "R5 first");
    rdChk(16'd1535, 32'h0, 1, 32'hFFFF_0F1F, "R5 last");
    rdChk(16'd1126, 32'h0, 1, 32'h0, "R5 neighbour untouched");
    // R6 accumulator halves
    wr(16'h2801, 32'h1111_1111);
    wr(16'h2802, 32'h2222_2222);
    wr(16'h2801, 32'h3333_3333);
    rdChk(16'h2802, 32'h0, 1, 32'h2222_2222, "R6 hi kept");
    rdChk(16'h2801, 32'h0, 1, 32'h3333_3333, "R6 lo replaced");
    // R7 pending register
    wrIrq(16'h1800, 32'h0, 32'h0000_00F0);
    wrEn = 1'b0;
    rdChk(16'h4802, 32'h0, 1, 32'h0000_00F0, "R7 set by irq");
    wr(16'h4802, 32'h0000_0030);
    rdChk(16'h4802, 32'h0, 1, 32'h0000_00C0, "R7 w1c");
    wrIrq(16'h4802, 32'h0000_0080, 32'h0000_0080);
    rdChk(16'h4802, 32'h0, 1, 32'h0000_00C0, "R7 set beats clear");
    wrIrq(16'h4802, 32'h0000_0040, 32'h0000_0001);
    rdChk(16'h4802, 32'h0, 1, 32'h0000_0081, "R7 clear and set other bits");
    // R8 power management
    curPc = 32'h0000_1000;
    wr(16'h4000, 32'h0000_0010);
    pulseChk(2, 1'b1, 32'h0000_1004, "R8 doze halt");
    pulseChk(2, 1'b0, 32'h0, "R8 pulse one cycle");
    wr(16'h4000, 32'h0000_000F);
    pulseChk(2, 1'b0, 32'h0, "R8 no halt");
    curPc = 32'h0000_2000;
    wr(16'h4000, 32'h0000_0020);
    pulseChk(2, 1'b1, 32'h0000_2004, "R8 sleep halt");
    rdChk(16'h4000, 32'h0, 1, 32'h0000_0020, "R8 stored");
    // R9 next PC
    curPc = 32'h0000_1000;
    wr(16'h0010, 32'h0000_3000);
    pulseChk(1, 1'b1, 32'h0000_3000, "R9 redirect");
    pulseChk(1, 1'b0, 32'h0, "R9 pulse one cycle");
    wr(16'h0010, 32'h0000_1000);
    pulseChk(1, 1'b0, 32'h0, "R9 same value");
    rdChk(16'h0010, 32'h0, 1, 32'h0000_1000, "R9 read curPc");
    // R10 default pass-through
    rdChk(16'h1800, 32'hDEAD_BEEF, 1, 32'hDEAD_BEEF, "R10 group3");
    rdChk(16'h0003, 32'h1357_9BDF, 1, 32'h1357_9BDF, "R10 number 3");
    rdChk(16'h000B, 32'h0BAD_F00D, 0, 32'h0BAD_F00D, "R10 rdEn low");
    pulseChk(1, 1'b0, 32'h0, "R1 idle tail");
    repeat (2) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule